// File: doc/BRIEF.md
# Video Stream Timing Tracker

This block watches a pixel-rate video stream made of a data-enable, a horizontal sync and a vertical sync. It sends the three control signals on after a fixed two-clock delay. While doing so it measures how many pixels make up an active line and how many active lines make up a frame. It also produces a column and row coordinate for every delayed active pixel, plus a one-cycle frame-start marker. A downstream pattern or overlay stage can use these to place content without knowing the source timing in advance.

Frame boundaries come from rising edges of the vertical sync input. Some sources never drive vertical sync. For those, the block treats a run of data-enable-low clocks longer than twice the measured line length as vertical blanking and starts a new frame there. An internal flag records whether vertical sync is being seen, and blanking-based frame starts apply only while that flag is clear.

Top module: `vid_timing_tracker`

## Requirements
- R1: `de_o`, `hs_o` and `vs_o` equal `de_i`, `hs_i` and `vs_i` as sampled two clock edges earlier, with no change in value.
- R2: `width_o` holds the number of consecutive clocks with `de_i` high in the most recent completed active run. It is updated on the edge that samples `de_i` low after a high, and it does not change otherwise.
- R3: A blanking event occurs on the edge that samples the (2·`width_o`+1)-th consecutive low `de_i`. A run of exactly 2·`width_o` low clocks produces no event, there is at most one event per low run, and there is none while `width_o` is 0.
- R4: A frame start occurs on an edge where `vs_i` is sampled high after low, or on a blanking event while the sync-present flag is clear. `frame_start_o` is a one-cycle pulse aligned with the delayed stream: it is high in the same cycle as the `de_o` value of that edge.
- R5: The sync-present flag is set by a `vs_i` rising edge. It is cleared on the second blanking event that has no `vs_i` rising edge since the last one. While the flag is set, blanking events do not start frames.
- R6: At a frame start, `height_o` takes the number of `de_i` rising edges counted since the previous frame start. A `de_i` rising edge on the same edge as the frame start counts toward the new frame.
- R7: When `de_o` is high, `col_o` is the 0-based index of that pixel within its active run.
- R8: When `de_o` is high, `row_o` is the 0-based index of that line since the last frame start. A line that begins on the same edge as a frame start is row 0.
- R9: While `rst` is high, all outputs are 0 and the sync-present flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_i | input | 1 | Incoming data enable |
| hs_i | input | 1 | Incoming horizontal sync |
| vs_i | input | 1 | Incoming vertical sync |
| de_o | output | 1 | Data enable delayed two clocks |
| hs_o | output | 1 | Horizontal sync delayed two clocks |
| vs_o | output | 1 | Vertical sync delayed two clocks |
| width_o | output | CNT_W | Measured active pixels per line |
| height_o | output | CNT_W | Measured active lines per frame |
| col_o | output | CNT_W | Column of the current delayed pixel |
| row_o | output | CNT_W | Row of the current delayed line |
| frame_start_o | output | 1 | One-cycle frame-start pulse, aligned with de_o |

## Verification
The critical coincidence is a frame start landing on the same edge as the first pixel of a line. In that case the line counter must restart and count the new line at once, and the row must read 0. This case is forced directly by raising `vs_i` and `de_i` together after a low gap. The check requires that `frame_start_o` and `de_o` appear together with `row_o` equal to 0 and that the next height counts that line. Random frames with mixed sync and no-sync segments also produce blanking events and line starts close together. Every cycle is compared against a bench model built from the requirements.

// File: rtl/vtt_pkg.sv
package vtt_pkg;

    localparam int DEF_CNT_W  = 12;
    localparam int PIPE_DEPTH = 2;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
        logic fs;
    } vstage_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_VSYNC = 2'd1,
        SRC_BLANK = 2'd2
    } fs_src_t;

endpackage

// File: rtl/vtt_delay.sv
module vtt_delay
    import vtt_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  vstage_t in_i,
    output vstage_t out_o
);
    localparam int WARM_W = $clog2(DEPTH + 1);

    vstage_t stg_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[0] <= '0;
                    else     stg_q[0] <= in_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[g] <= '0;
                    else     stg_q[g] <= stg_q[g-1];
                end
            end
        end
    endgenerate

    assign out_o = stg_q[DEPTH-1];

    logic [WARM_W-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                           warm_q <= '0;
        else if (warm_q != WARM_W'(DEPTH)) warm_q <= warm_q + 1'b1;
    end

    // R1: output equals input from two edges back once the pipe is filled
    a_r1_ctrl_delay: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM_W'(DEPTH)) |->
            (out_o.de == $past(in_i.de, 2) && out_o.hs == $past(in_i.hs, 2)
             && out_o.vs == $past(in_i.vs, 2)));
endmodule

// File: rtl/vtt_measure.sv
module vtt_measure #(
    parameter int CNT_W = vtt_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    output logic             de_prev_o,
    output logic [CNT_W-1:0] width_o,
    output logic             blank_evt_o
);
    logic             de_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] width_q;
    logic [CNT_W:0]   low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q    <= 1'b0;
            run_q   <= '0;
            width_q <= '0;
            low_q   <= '0;
        end else begin
            de_q <= de_i;
            if (de_i) begin
                low_q <= '0;
                if (!de_q)           run_q <= CNT_W'(1);
                else if (run_q != '1) run_q <= run_q + 1'b1;
            end else begin
                if (low_q != '1) low_q <= low_q + 1'b1;
                if (de_q)        width_q <= run_q;
            end
        end
    end

    // event on the sample that makes the low run exceed twice the line length
    assign blank_evt_o = !de_i && (width_q != '0) && (low_q == {width_q, 1'b0});
    assign width_o     = width_q;
    assign de_prev_o   = de_q;

    // R2: width changes only on a falling data enable
    a_r2_width_hold: assert property (@(posedge clk) disable iff (rst)
        !(de_q && !de_i) |=> $stable(width_q));

    // R3: at most one blanking event per low run
    a_r3_single_event: assert property (@(posedge clk) disable iff (rst)
        blank_evt_o |=> !blank_evt_o);
endmodule

// File: rtl/vtt_frame.sv
module vtt_frame
    import vtt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    input  logic             de_prev_i,
    input  logic             vs_i,
    input  logic             blank_evt_i,
    output logic             fs_o,
    output logic [CNT_W-1:0] height_o,
    output logic [CNT_W-1:0] row_o
);
    logic             vs_q;
    logic             vsp_q;
    logic             miss_q;
    logic [CNT_W-1:0] line_q;
    logic [CNT_W-1:0] height_q;
    logic [CNT_W-1:0] row_q;
    logic             vs_rise;
    logic             de_rise;
    fs_src_t          src;

    assign vs_rise = vs_i && !vs_q;
    assign de_rise = de_i && !de_prev_i;

    always_comb begin
        if (vs_rise)                    src = SRC_VSYNC;
        else if (blank_evt_i && !vsp_q) src = SRC_BLANK;
        else                            src = SRC_NONE;
    end

    assign fs_o = (src != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q     <= 1'b0;
            vsp_q    <= 1'b0;
            miss_q   <= 1'b0;
            line_q   <= '0;
            height_q <= '0;
            row_q    <= '0;
        end else begin
            vs_q <= vs_i;
            if (vs_rise) begin
                vsp_q  <= 1'b1;
                miss_q <= 1'b0;
            end else if (blank_evt_i && vsp_q) begin
                if (miss_q) begin
                    vsp_q  <= 1'b0;
                    miss_q <= 1'b0;
                end else begin
                    miss_q <= 1'b1;
                end
            end
            if (fs_o) begin
                height_q <= line_q;
                line_q   <= de_rise ? CNT_W'(1) : '0;
            end else if (de_rise && line_q != '1) begin
                line_q <= line_q + 1'b1;
            end
            if (de_rise) row_q <= fs_o ? '0 : line_q;
        end
    end

    assign height_o = height_q;
    assign row_o    = row_q;

    // R5: a sync edge always marks sync as present
    a_r5_sync_seen: assert property (@(posedge clk) disable iff (rst)
        vs_rise |=> vsp_q);

    // R6: the line count restarts at a frame start
    a_r6_line_restart: assert property (@(posedge clk) disable iff (rst)
        fs_o |=> (line_q <= CNT_W'(1)));
endmodule

// File: rtl/vid_timing_tracker.sv
module vid_timing_tracker
    import vtt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    input  logic             hs_i,
    input  logic             vs_i,
    output logic             de_o,
    output logic             hs_o,
    output logic             vs_o,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] height_o,
    output logic [CNT_W-1:0] col_o,
    output logic [CNT_W-1:0] row_o,
    output logic             frame_start_o
);
    logic             de_prev;
    logic             blank_evt;
    logic             fs;
    logic [CNT_W-1:0] row_s1;
    logic [CNT_W-1:0] col_s1;
    vstage_t          stg_in;
    vstage_t          stg_out;

    vtt_measure #(.CNT_W(CNT_W)) u_measure (
        .clk        (clk),
        .rst        (rst),
        .de_i       (de_i),
        .de_prev_o  (de_prev),
        .width_o    (width_o),
        .blank_evt_o(blank_evt)
    );

    vtt_frame #(.CNT_W(CNT_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .de_i       (de_i),
        .de_prev_i  (de_prev),
        .vs_i       (vs_i),
        .blank_evt_i(blank_evt),
        .fs_o       (fs),
        .height_o   (height_o),
        .row_o      (row_s1)
    );

    assign stg_in = '{de: de_i, hs: hs_i, vs: vs_i, fs: fs};

    vtt_delay #(.DEPTH(PIPE_DEPTH)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .in_i (stg_in),
        .out_o(stg_out)
    );

    // first stage column counter, second stage output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            col_s1 <= '0;
            col_o  <= '0;
            row_o  <= '0;
        end else begin
            if (de_i && de_prev && col_s1 != '1) col_s1 <= col_s1 + 1'b1;
            else if (!(de_i && de_prev))         col_s1 <= '0;
            col_o <= col_s1;
            row_o <= row_s1;
        end
    end

    assign de_o          = stg_out.de;
    assign hs_o          = stg_out.hs;
    assign vs_o          = stg_out.vs;
    assign frame_start_o = stg_out.fs;

    // R7: each active run starts at column 0
    a_r7_col_start: assert property (@(posedge clk) disable iff (rst)
        $rose(de_o) |-> (col_o == '0));

    // R7: columns step by one inside a run
    a_r7_col_step: assert property (@(posedge clk) disable iff (rst)
        (de_o && $past(de_o) && $past(col_o) != '1) |-> (col_o == $past(col_o) + 1'b1));

    // R8: a line shown with the frame marker is row 0
    a_r8_row_first: assert property (@(posedge clk) disable iff (rst)
        (frame_start_o && de_o) |-> (row_o == '0));
endmodule

// File: tb/tb_vid_timing_tracker.sv
`timescale 1ns/1ps
module tb_vid_timing_tracker;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
    logic de_o, hs_o, vs_o, frame_start_o;
    logic [CW-1:0] width_o, height_o, col_o, row_o;

    vid_timing_tracker #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
        .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .width_o(width_o),
        .height_o(height_o), .col_o(col_o), .row_o(row_o),
        .frame_start_o(frame_start_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0, fs_seen = 0, collide_seen = 0;
    bit done = 0;

    // reference model state
    int m_pde, m_pvs, m_run, m_w, m_low, m_vsp, m_miss, m_line, m_h;
    int s_de, s_hs, s_vs, s_fs, s_col, s_row;
    int o_de, o_hs, o_vs, o_fs, o_col, o_row;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_pde = 0; m_pvs = 0; m_run = 0; m_w = 0; m_low = 0; m_vsp = 0;
        m_miss = 0; m_line = 0; m_h = 0;
        s_de = 0; s_hs = 0; s_vs = 0; s_fs = 0; s_col = 0; s_row = 0;
        o_de = 0; o_hs = 0; o_vs = 0; o_fs = 0; o_col = 0; o_row = 0;
    endtask

    // one clock edge of the stream as the requirements describe it
    task automatic model_step(int d, int h, int v);
        int rise_de, rise_vs, blank, fs;
        rise_de = d && !m_pde;
        rise_vs = v && !m_pvs;
        blank   = !d && (m_w != 0) && (m_low == 2 * m_w);
        fs      = rise_vs || (blank && !m_vsp);
        o_de = s_de; o_hs = s_hs; o_vs = s_vs; o_fs = s_fs; o_col = s_col; o_row = s_row;
        s_de = d; s_hs = h; s_vs = v; s_fs = fs;
        s_col = (d && m_pde) ? s_col + 1 : 0;
        if (rise_de) s_row = fs ? 0 : m_line;
        if (d) begin
            m_run = m_pde ? m_run + 1 : 1;
            m_low = 0;
        end else begin
            m_low++;
            if (m_pde) m_w = m_run;
        end
        if (rise_vs) begin
            m_vsp = 1; m_miss = 0;
        end else if (blank && m_vsp) begin
            if (m_miss) begin m_vsp = 0; m_miss = 0; end
            else m_miss = 1;
        end
        if (fs) begin
            m_h = m_line;
            m_line = rise_de ? 1 : 0;
        end else if (rise_de) begin
            m_line++;
        end
        m_pde = d; m_pvs = v;
    endtask

    task automatic cyc(int d, int h, int v);
        @(negedge clk);
        chk("R1 de", de_o, o_de);
        chk("R1 hs", hs_o, o_hs);
        chk("R1 vs", vs_o, o_vs);
        chk("R4 frame start", frame_start_o, o_fs);
        chk("R2 width", width_o, m_w);
        chk("R6 height", height_o, m_h);
        if (o_de) begin
            chk("R7 column", col_o, o_col);
            chk("R8 row", row_o, o_row);
        end
        if (frame_start_o) fs_seen++;
        if (frame_start_o && de_o) begin
            collide_seen++;
            chk("R8 row at coincident start", row_o, 0);
        end
        de_i = d[0]; hs_i = h[0]; vs_i = v[0];
        model_step(d, h, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; de_i = 0; hs_i = 0; vs_i = 0;
        repeat (3) @(negedge clk);
        chk("R9 de_o", de_o, 0);
        chk("R9 vs_o", vs_o, 0);
        chk("R9 width", width_o, 0);
        chk("R9 height", height_o, 0);
        chk("R9 col", col_o, 0);
        chk("R9 row", row_o, 0);
        chk("R9 frame start", frame_start_o, 0);
        model_clear();
        rst = 0;
        model_step(0, 0, 0);
    endtask

    task automatic idle(int n, int v);
        for (int i = 0; i < n; i++) cyc(0, 0, v);
    endtask

    task automatic line(int w, int hb);
        for (int i = 0; i < w; i++) cyc(1, 0, 0);
        for (int i = 0; i < hb; i++) cyc(0, (i == 0) ? 1 : 0, 0);
    endtask

    // vblank of length vb, sync high for 3 clocks starting at vpos when use_vs
    task automatic vblank(int vb, int use_vs, int vpos);
        for (int i = 0; i < vb; i++)
            cyc(0, 0, (use_vs && i >= vpos && i < vpos + 3) ? 1 : 0);
    endtask

    int base, w, nl;

    initial begin
        void'($urandom(32'd20240611));
        model_clear();

        // R9 reset state, then R3 threshold: low run of 2w gives nothing, 2w+1 starts a frame
        do_reset();
        base = fs_seen;
        for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < 3; l++) line(8, 16);
            vblank(1, 0, 0);
        end
        idle(6, 0);
        chk("R3 frames from 2w+1 low runs only", fs_seen - base, 2);
        chk("R2 measured width", width_o, 8);
        chk("R6 height of inferred frame", height_o, 3);

        // R5: sync seen, then removed; third blanking event is the first to start a frame
        do_reset();
        for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < 3; l++) line(8, 4);
            vblank(43, 1, 20);
        end
        base = fs_seen;
        for (int f = 0; f < 3; f++) begin
            for (int l = 0; l < 3; l++) line(8, 4);
            vblank(40, 0, 0);
        end
        idle(4, 0);
        chk("R5 frame starts after sync loss", fs_seen - base, 1);
        chk("R6 height across ignored events", height_o, 9);

        // R4/R8: sync rise and line start on the same edge
        base = collide_seen;
        idle(5, 0);
        cyc(1, 0, 1);
        for (int i = 0; i < 7; i++) cyc(1, 0, 1);
        idle(3, 0);
        line(8, 4);
        vblank(30, 0, 0);
        cyc(0, 0, 1);
        idle(4, 1);
        chk("R4 coincident start observed", (collide_seen - base > 0) ? 1 : 0, 1);
        chk("R6 line on start edge counted", height_o, 2);

        // random frames, sync present or absent by segment
        for (int f = 0; f < 40; f++) begin
            w  = 4 + int'($urandom % 37);
            nl = 1 + int'($urandom % 8);
            for (int l = 0; l < nl; l++) begin
                for (int i = 0; i < w; i++) cyc(1, int'($urandom % 2), 0);
                if (l != nl - 1) begin
                    int hb;
                    hb = 1 + int'($urandom % (2 * w));
                    for (int i = 0; i < hb; i++) cyc(0, int'($urandom % 2), 0);
                end
            end
            vblank(2 * w + 1 + int'($urandom % 20), ((f / 8) % 2 == 0) ? 1 : 0,
                   int'($urandom % (2 * w)));
        end
        idle(4, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule